// File: doc/BRIEF.md
# Line State Match Interrupt

This block watches the line state that a physical-layer receiver reports and raises a sticky interrupt event when that state is one software asked to hear about. A four-bit selection mask picks the states of interest: Quiet, Master, Halt and Idle. Idle is special. It only counts as present once sixteen back-to-back Idle symbols have been received, so a short run of idle fill does not trip the event.

When the mask is all zeros the block works in a second mode. The event then fires on any change of the line-state code or of the unknown-line-state flag. The mask resets to zero in the surrounding register, so after reset the block is in this any-change mode.

The event bit is level-sticky. It stays high until software pulses the clear input. The block is meant to feed one bit of a larger interrupt event register.

Top module: `lsm_line_match`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `evt_flag` is 0.
- R2: The 3-bit `ls_code` encoding is Quiet=0, Idle=1, Master=2 and Halt=3. Codes 4 to 7 are other states. The mask bits select states as follows: bit 3 selects Quiet, bit 2 selects Master, bit 1 selects Halt and bit 0 selects Idle. `evt_flag` rises on the first clock edge at which a selected state becomes present.
- R3: With several mask bits set, entering any one of the selected states raises the event, including a move from one selected state directly into another.
- R4: While a selected state simply persists, no new event is produced, so a cleared flag stays low.
- R5: Idle counts as present only once 16 consecutive Idle symbols (`sym_valid`=1, `sym_is_idle`=1) have been taken. The event appears at the edge after the sixteenth such symbol. Fifteen symbols are not enough. Cycles with `sym_valid`=0 neither count nor break the run.
- R6: A valid symbol that is not Idle restarts the idle count at zero. The count saturates at the threshold and does not wrap.
- R7: With mask 0, any change of `ls_code` or of `ls_unknown` from one cycle to the next sets `evt_flag` at that edge.
- R8: With mask 0, no event is raised while `ls_code` and `ls_unknown` are stable.
- R9: `evt_flag` holds until `evt_clear` is sampled high. If a set and a clear occur in the same cycle, the set wins.
- R10: While `ls_unknown` is 1, no state counts as selected in mask mode. When the flag falls while a selected state is present, that counts as entry into the state.
- R11: A state that is not selected by the mask, including codes 4 to 7, never raises the event in mask mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ls_code | input | 3 | Current decoded line-state code |
| ls_unknown | input | 1 | Receiver cannot classify the line state |
| sym_valid | input | 1 | A received symbol is presented this cycle |
| sym_is_idle | input | 1 | The presented symbol is an Idle symbol |
| match_mask | input | 4 | State selection mask; 0 selects any-change mode |
| evt_clear | input | 1 | Clear request for the sticky event |
| evt_flag | output | 1 | Sticky line-state match event |

## Verification
Every result is due one clock edge after the inputs that cause it. The one exception is the qualified Idle condition, which needs one further edge after the sixteenth Idle symbol because the idle count is registered before it is compared. The driver changes inputs on the falling edge and queues one expected flag value per cycle. The monitor pops that value one time unit after the next rising edge, so each comparison lands on the cycle in which the flag is due. The Idle runs are laid out so that the 15-symbol, 16-symbol and saturation cases each hit that extra edge exactly.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int LS_W     = 3;
  localparam int NUM_SEL  = 4;
  localparam int IDLE_THR = 16;

  typedef enum logic [LS_W-1:0] {
    LS_QUIET  = 3'd0,
    LS_IDLE   = 3'd1,
    LS_MASTER = 3'd2,
    LS_HALT   = 3'd3,
    LS_ACTIVE = 3'd4,
    LS_NOISE  = 3'd5,
    LS_RSV6   = 3'd6,
    LS_RSV7   = 3'd7
  } line_state_e;

  localparam int SEL_IDLE   = 0;
  localparam int SEL_HALT   = 1;
  localparam int SEL_MASTER = 2;
  localparam int SEL_QUIET  = 3;

  // Map a mask bit position to the line state it selects.
  function automatic line_state_e sel_to_state(input int idx);
    case (idx)
      SEL_IDLE:   sel_to_state = LS_IDLE;
      SEL_HALT:   sel_to_state = LS_HALT;
      SEL_MASTER: sel_to_state = LS_MASTER;
      default:    sel_to_state = LS_QUIET;
    endcase
  endfunction
endpackage

// File: rtl/lsm_idle_qual.sv
module lsm_idle_qual #(
  parameter int THR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_valid,
  input  logic sym_is_idle,
  output logic idle_ok
);
  localparam int CW = $clog2(THR + 1);
  localparam logic [CW-1:0] CMAX = CW'(THR);

  logic [CW-1:0] run_cnt;

  // Count consecutive valid Idle symbols, saturating at THR.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (sym_valid) begin
      if (!sym_is_idle)
        run_cnt <= '0;
      else if (run_cnt != CMAX)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign idle_ok = (run_cnt == CMAX);
endmodule

// File: rtl/lsm_state_sel.sv
module lsm_state_sel
  import lsm_pkg::*;
#(
  parameter int NSEL = NUM_SEL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LS_W-1:0] ls_code,
  input  logic            ls_unknown,
  input  logic            idle_ok,
  input  logic [NSEL-1:0] mask,
  output logic            sel_rise
);
  logic [NSEL-1:0] present;
  logic [NSEL-1:0] sel_now;
  logic [NSEL-1:0] sel_prev;

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_sel
    localparam line_state_e ST = sel_to_state(gi);
    if (gi == SEL_IDLE) begin : g_idle
      assign present[gi] = !ls_unknown && (ls_code == ST) && idle_ok;
    end else begin : g_plain
      assign present[gi] = !ls_unknown && (ls_code == ST);
    end
  end

  assign sel_now = present & mask;

  // Per-state edge memory, so moving between selected states counts as entry.
  always_ff @(posedge clk) begin
    if (rst) sel_prev <= '0;
    else     sel_prev <= sel_now;
  end

  assign sel_rise = |(sel_now & ~sel_prev);
endmodule

// File: rtl/lsm_change_det.sv
module lsm_change_det
  import lsm_pkg::*;
(
  input  logic            clk,
  input  logic [LS_W-1:0] ls_code,
  input  logic            ls_unknown,
  output logic            changed
);
  logic [LS_W-1:0] code_q;
  logic            unk_q;

  // Sampled every cycle, reset included, so the first post-reset compare
  // is against the value actually present during reset.
  always_ff @(posedge clk) begin
    code_q <= ls_code;
    unk_q  <= ls_unknown;
  end

  assign changed = (code_q != ls_code) || (unk_q != ls_unknown);
endmodule

// File: rtl/lsm_event_reg.sv
module lsm_event_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/lsm_line_match.sv
module lsm_line_match
  import lsm_pkg::*;
#(
  parameter int THR  = IDLE_THR,
  parameter int NSEL = NUM_SEL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LS_W-1:0] ls_code,
  input  logic            ls_unknown,
  input  logic            sym_valid,
  input  logic            sym_is_idle,
  input  logic [NSEL-1:0] match_mask,
  input  logic            evt_clear,
  output logic            evt_flag
);
  logic idle_ok;
  logic sel_rise;
  logic changed;
  logic any_mode;
  logic set_req;

  lsm_idle_qual #(.THR(THR)) u_idle (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .sym_is_idle(sym_is_idle),
    .idle_ok    (idle_ok)
  );

  lsm_state_sel #(.NSEL(NSEL)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .ls_code   (ls_code),
    .ls_unknown(ls_unknown),
    .idle_ok   (idle_ok),
    .mask      (match_mask),
    .sel_rise  (sel_rise)
  );

  lsm_change_det u_chg (
    .clk       (clk),
    .ls_code   (ls_code),
    .ls_unknown(ls_unknown),
    .changed   (changed)
  );

  assign any_mode = (match_mask == '0);
  assign set_req  = any_mode ? changed : sel_rise;

  lsm_event_reg u_evt (
    .clk    (clk),
    .rst    (rst),
    .set_req(set_req),
    .clr_req(evt_clear),
    .flag   (evt_flag)
  );
endmodule

// File: rtl/lsm_line_match_chk.sv
module lsm_line_match_chk
  import lsm_pkg::*;
#(
  parameter int NSEL = NUM_SEL
) (
  input logic            clk,
  input logic            rst,
  input logic [LS_W-1:0] ls_code,
  input logic            ls_unknown,
  input logic            sym_valid,
  input logic            sym_is_idle,
  input logic [NSEL-1:0] match_mask,
  input logic            evt_clear,
  input logic            evt_flag,
  input logic            idle_ok
);
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !evt_flag);

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    evt_flag && !evt_clear |=> evt_flag);

  assert_drop_needs_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(evt_flag) |-> $past(evt_clear));

  assert_idle_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) && ($past(match_mask) == NSEL'(1)) |->
      $past(idle_ok) && ($past(ls_code) == LS_IDLE));

  assert_unknown_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) && ($past(match_mask) != '0) |-> !$past(ls_unknown));

  assert_change_only_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) && ($past(match_mask) == '0) |->
      ($past(ls_code) != $past(ls_code, 2)) ||
      ($past(ls_unknown) != $past(ls_unknown, 2)));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    sym_valid && !sym_is_idle |=> !idle_ok);
endmodule

bind lsm_line_match lsm_line_match_chk #(.NSEL(NSEL)) u_chk (.*);

// File: tb/test_lsm_line_match.sv
`timescale 1ns/1ps
module test_lsm_line_match;
  localparam logic [2:0] QU = 3'd0, ID = 3'd1, MA = 3'd2, HA = 3'd3, AC = 3'd4;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ls_code = QU;
  logic       ls_unknown = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_is_idle = 1'b0;
  logic [3:0] match_mask = 4'd0;
  logic       evt_clear = 1'b0;
  logic       evt_flag;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  lsm_line_match i_lsm_line_match (
    .clk(clk), .rst(rst), .ls_code(ls_code), .ls_unknown(ls_unknown),
    .sym_valid(sym_valid), .sym_is_idle(sym_is_idle),
    .match_mask(match_mask), .evt_clear(evt_clear), .evt_flag(evt_flag)
  );

  // Driver: one call per cycle, queues the flag expected after the next edge.
  task automatic drv(input logic r, input logic [2:0] c, input logic u,
                     input logic sv, input logic si, input logic [3:0] m,
                     input logic cl, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; ls_code = c; ls_unknown = u; sym_valid = sv;
    sym_is_idle = si; match_mask = m; evt_clear = cl;
    it.exp = e; it.req = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares one queued item per cycle, just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_checks++;
        if (evt_flag !== it.exp) begin
          n_fail++;
          $display("FAIL %s: evt_flag=%b expected %b", it.req, evt_flag, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset
    for (int i = 0; i < 3; i++) drv(1, QU, 0, 0, 0, 4'd0, 0, 0, "R1");
    drv(0, QU, 0, 0, 0, 4'd0, 0, 0, "R1");
    drv(0, QU, 0, 0, 0, 4'd0, 0, 0, "R8");
    // any-change mode
    drv(0, HA, 0, 0, 0, 4'd0, 0, 1, "R7");
    drv(0, HA, 0, 0, 0, 4'd0, 1, 0, "R9");
    drv(0, HA, 0, 0, 0, 4'd0, 0, 0, "R8");
    drv(0, HA, 1, 0, 0, 4'd0, 0, 1, "R7");
    drv(0, HA, 0, 0, 0, 4'd0, 1, 1, "R9");
    drv(0, HA, 0, 0, 0, 4'd0, 1, 0, "R9");
    // mask mode, single state
    drv(0, HA, 0, 0, 0, 4'b1000, 0, 0, "R11");
    drv(0, QU, 0, 0, 0, 4'b1000, 0, 1, "R2");
    drv(0, QU, 0, 0, 0, 4'b1000, 1, 0, "R9");
    for (int i = 0; i < 3; i++) drv(0, QU, 0, 0, 0, 4'b1000, 0, 0, "R4");
    drv(0, MA, 0, 0, 0, 4'b0100, 0, 1, "R2");
    drv(0, MA, 0, 0, 0, 4'b0100, 1, 0, "R9");
    // multiple selected states
    drv(0, HA, 0, 0, 0, 4'b0110, 0, 1, "R3");
    drv(0, HA, 0, 0, 0, 4'b0110, 1, 0, "R9");
    drv(0, AC, 0, 0, 0, 4'b0110, 0, 0, "R11");
    drv(0, QU, 0, 0, 0, 4'b0110, 0, 0, "R11");
    drv(0, MA, 0, 0, 0, 4'b0110, 0, 1, "R3");
    drv(0, MA, 0, 0, 0, 4'b0110, 1, 0, "R9");
    // unknown flag
    drv(0, HA, 1, 0, 0, 4'b0110, 0, 0, "R10");
    drv(0, HA, 1, 0, 0, 4'b0110, 0, 0, "R10");
    drv(0, HA, 0, 0, 0, 4'b0110, 0, 1, "R10");
    drv(0, HA, 0, 0, 0, 4'b0110, 1, 0, "R9");
    // idle qualification
    drv(0, ID, 0, 0, 0, 4'b0001, 0, 0, "R5");
    for (int i = 0; i < 15; i++) drv(0, ID, 0, 1, 1, 4'b0001, 0, 0, "R5");
    drv(0, ID, 0, 0, 0, 4'b0001, 0, 0, "R5");
    drv(0, ID, 0, 1, 0, 4'b0001, 0, 0, "R6");
    for (int i = 0; i < 16; i++) begin
      drv(0, ID, 0, 1, 1, 4'b0001, 0, 0, "R5");
      if (i == 7) drv(0, ID, 0, 0, 0, 4'b0001, 0, 0, "R5");
    end
    drv(0, ID, 0, 0, 0, 4'b0001, 0, 1, "R5");
    drv(0, ID, 0, 0, 0, 4'b0001, 1, 0, "R9");
    drv(0, ID, 0, 0, 0, 4'b0001, 0, 0, "R4");
    drv(0, ID, 0, 1, 0, 4'b0001, 0, 0, "R6");
    drv(0, ID, 0, 0, 0, 4'b0001, 0, 0, "R6");
    for (int i = 0; i < 16; i++) drv(0, ID, 0, 1, 1, 4'b0001, 0, 0, "R5");
    for (int i = 0; i < 20; i++) drv(0, ID, 0, 1, 1, 4'b0001, 0, 1, "R6");
    drv(0, ID, 0, 1, 1, 4'b0001, 1, 0, "R6");
    for (int i = 0; i < 4; i++) drv(0, ID, 0, 1, 1, 4'b0001, 0, 0, "R4");
    drv(1, ID, 0, 0, 0, 4'b0001, 0, 0, "R1");
    drv(0, ID, 0, 0, 0, 4'b0000, 0, 0, "R1");
    drv(0, ID, 0, 0, 0, 4'b0000, 0, 0, "R1");
    wait (sb.size() == 0);
    @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule